// File: doc/BRIEF.md
# Dual-Thread Micro-Op Queue with Mode-Dependent Partitioning

This block buffers decoded micro-ops for two hardware threads that share one core. Each thread has its own enqueue port with a valid/ready handshake. A single dequeue port reads the oldest entry of whichever thread the select input names. All threads draw on one pool of entries. Each thread's entries form an independent first-in first-out stream, and entries from one thread never show up in the other thread's stream.

A two-bit mode input from the thread controller decides how the pool is split. When both threads run, each thread may hold at most half of the pool. When one thread runs alone, it may hold the whole pool, and the idle thread cannot enqueue at all.

A change of mode never flushes anything. A thread that holds more than its new share keeps those entries and drains them in order. Its ready stays low until its occupancy falls below the new limit. Each thread's occupancy is reported on its own output.

Top module: `smt_uop_queue`

## Requirements
- R1: After reset both occupancies are 0 and `deqValid` is 0. Each thread's ready follows R3 to R5 for the current mode, with zero occupancy.
- R2: Each thread's entries dequeue in the order that thread enqueued them. Interleaved traffic from the other thread does not affect that order.
- R3: With `mode` = 2'b11 (both threads active), a thread's ready is high exactly when its occupancy is below 8 and at least one entry is free.
- R4: With `mode` = 2'b01 (thread 0 alone) or 2'b10 (thread 1 alone), the active thread's ready is high exactly when its occupancy is below 16 and at least one entry is free. The active thread can fill all 16 entries.
- R5: A thread whose mode bit is 0 has its ready held low. Bit 0 of `mode` belongs to thread 0 and bit 1 to thread 1. With `mode` = 2'b00 neither thread is ready.
- R6: When the mode switches from single-thread to 2'b11, no entry is lost. A thread holding 8 or more entries keeps ready low until its occupancy drops below 8. Its entries still drain in order.
- R7: `deqReq` for a thread with occupancy 0 gives `deqValid` = 0 and changes no occupancy. `deqSel` = 0 selects thread 0 and 1 selects thread 1.
- R8: Both threads can enqueue and one thread can dequeue in the same cycle, and all three transfers take effect.
- R9: `occ0` and `occ1` equal the number of entries each thread holds. A thread's ready is low when all 16 entries are occupied, even if that thread is below its own limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Active-thread mask: bit 0 is thread 0, bit 1 is thread 1 |
| enqValid0 | input | 1 | Thread 0 offers a micro-op |
| enqData0 | input | DATA_W | Thread 0 micro-op payload |
| enqReady0 | output | 1 | Thread 0 may enqueue this cycle |
| enqValid1 | input | 1 | Thread 1 offers a micro-op |
| enqData1 | input | DATA_W | Thread 1 micro-op payload |
| enqReady1 | output | 1 | Thread 1 may enqueue this cycle |
| deqReq | input | 1 | Dequeue request |
| deqSel | input | 1 | Thread to dequeue from |
| deqValid | output | 1 | Requested thread had an entry, which is popped at this edge |
| deqData | output | DATA_W | Oldest entry of the selected thread |
| occ0 | output | 5 | Thread 0 occupancy |
| occ1 | output | 5 | Thread 1 occupancy |

## Verification
Some properties are checked by assertions on every cycle:
- Total occupancy never exceeds the pool, and the free-slot mask agrees with the two counts.
- The two enqueues in one cycle never land in the same slot.
- A popped slot is always an occupied one.
- An idle thread is never ready.
- Under both-thread mode, a thread at or above half the pool never grows.
- An empty dequeue alone leaves both counts unchanged.

Other behaviour can only be shown by the bench's scenarios against its reference queues:
- Per-thread ordering under mixed traffic.
- Survival of over-limit entries across a mode switch.
- The exact cycle at which ready returns.

// File: rtl/uopq_pkg.sv
package uopq_pkg;
  localparam int QDEPTH = 16;
  localparam int IDXW   = $clog2(QDEPTH);

  typedef struct packed {
    logic            wr0;
    logic [IDXW-1:0] wr0Idx;
    logic            wr1;
    logic [IDXW-1:0] wr1Idx;
    logic [IDXW-1:0] rdIdx;
  } uopq_strobe_t;
endpackage

// File: rtl/uopq_slot_pick.sv
module uopq_slot_pick #(
  parameter int DEPTH     = 16,
  parameter bit LOW_FIRST = 1'b1,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] freeMask,
  output logic             found,
  output logic [IW-1:0]    slot
);
  generate
    if (LOW_FIRST) begin : g_low
      always_comb begin
        found = 1'b0;
        slot  = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
          if (freeMask[i]) begin
            found = 1'b1;
            slot  = IW'(i);
          end
        end
      end
    end else begin : g_high
      always_comb begin
        found = 1'b0;
        slot  = '0;
        for (int i = 0; i < DEPTH; i++) begin
          if (freeMask[i]) begin
            found = 1'b1;
            slot  = IW'(i);
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/uopq_ctrl.sv
module uopq_ctrl
  import uopq_pkg::*;
#(
  parameter int DEPTH = QDEPTH,
  localparam int HALF = DEPTH / 2,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    mode,
  input  logic          enqValid0,
  input  logic          enqValid1,
  output logic          enqReady0,
  output logic          enqReady1,
  input  logic          deqReq,
  input  logic          deqSel,
  output logic          deqValid,
  output logic [CW-1:0] occ0,
  output logic [CW-1:0] occ1,
  output uopq_strobe_t  strobe
);
  logic [CW-1:0]    cnt  [2];
  logic [IW-1:0]    head [2];
  logic [IW-1:0]    tail [2];
  logic [IW-1:0]    nextPtr [DEPTH];
  logic [DEPTH-1:0] freeMask;

  logic [CW-1:0] limit;
  logic [CW:0]   usedTotal;
  logic          anyFree;
  logic [1:0]    rdy, push, pop, headLoad;
  logic [IW-1:0] slot [2];
  logic          found0, found1;
  logic [DEPTH-1:0] pushMask, popMask;

  uopq_slot_pick #(.DEPTH(DEPTH), .LOW_FIRST(1'b1)) pickLow (
    .freeMask(freeMask), .found(found0), .slot(slot[0]));
  uopq_slot_pick #(.DEPTH(DEPTH), .LOW_FIRST(1'b0)) pickHigh (
    .freeMask(freeMask), .found(found1), .slot(slot[1]));

  always_comb begin
    limit     = (mode == 2'b11) ? CW'(HALF) : CW'(DEPTH);
    usedTotal = {1'b0, cnt[0]} + {1'b0, cnt[1]};
    anyFree   = usedTotal < (CW+1)'(DEPTH);
    for (int t = 0; t < 2; t++) begin
      rdy[t] = mode[t] && (cnt[t] < limit) && anyFree;
    end
    push[0]  = enqValid0 && rdy[0] && found0;
    push[1]  = enqValid1 && rdy[1] && found1;
    deqValid = deqReq && (cnt[deqSel] != '0);
    pop[0]   = deqValid && !deqSel;
    pop[1]   = deqValid && deqSel;
    for (int t = 0; t < 2; t++) begin
      headLoad[t] = push[t] && ((cnt[t] == '0) || ((cnt[t] == CW'(1)) && pop[t]));
    end
    pushMask = '0;
    popMask  = '0;
    for (int t = 0; t < 2; t++) begin
      if (push[t]) pushMask[slot[t]] = 1'b1;
      if (pop[t])  popMask[head[t]]  = 1'b1;
    end
  end

  assign enqReady0 = rdy[0];
  assign enqReady1 = rdy[1];
  assign occ0      = cnt[0];
  assign occ1      = cnt[1];

  always_comb begin
    strobe.wr0    = push[0];
    strobe.wr0Idx = slot[0];
    strobe.wr1    = push[1];
    strobe.wr1Idx = slot[1];
    strobe.rdIdx  = head[deqSel];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      freeMask <= '1;
      for (int t = 0; t < 2; t++) begin
        cnt[t]  <= '0;
        head[t] <= '0;
        tail[t] <= '0;
      end
    end else begin
      freeMask <= (freeMask & ~pushMask) | popMask;
      for (int t = 0; t < 2; t++) begin
        cnt[t] <= cnt[t] + CW'(push[t]) - CW'(pop[t]);
        if (headLoad[t])  head[t] <= slot[t];
        else if (pop[t])  head[t] <= nextPtr[head[t]];
        if (push[t])      tail[t] <= slot[t];
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int t = 0; t < 2; t++) begin
      if (push[t] && !headLoad[t]) nextPtr[tail[t]] <= slot[t];
    end
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    usedTotal <= (CW+1)'(DEPTH));

  // R9
  free_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(freeMask) == int'(DEPTH) - int'(usedTotal));

  // R8
  distinct_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (push[0] && push[1]) |-> (slot[0] != slot[1]));

  // R2
  pop_occupied_chk: assert property (@(posedge clk) disable iff (!rstN)
    deqValid |-> !freeMask[strobe.rdIdx]);

  // R5
  idle_t0_chk: assert property (@(posedge clk) disable iff (!rstN)
    !mode[0] |-> !enqReady0);

  // R5
  idle_t1_chk: assert property (@(posedge clk) disable iff (!rstN)
    !mode[1] |-> !enqReady1);

  // R3
  half_cap0_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b11 && cnt[0] >= CW'(HALF)) |=> (cnt[0] <= $past(cnt[0])));

  // R3
  half_cap1_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b11 && cnt[1] >= CW'(HALF)) |=> (cnt[1] <= $past(cnt[1])));

  // R7
  empty_deq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (deqReq && cnt[deqSel] == '0 && !enqValid0 && !enqValid1)
      |=> ($stable(cnt[0]) && $stable(cnt[1])));
endmodule

// File: rtl/uopq_data.sv
module uopq_data
  import uopq_pkg::*;
#(
  parameter int DEPTH  = QDEPTH,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  uopq_strobe_t      strobe,
  input  logic [DATA_W-1:0] wrData0,
  input  logic [DATA_W-1:0] wrData1,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (strobe.wr0) mem[strobe.wr0Idx] <= wrData0;
    if (strobe.wr1) mem[strobe.wr1Idx] <= wrData1;
  end

  assign rdData = mem[strobe.rdIdx];

  // R8
  dual_write_chk: assert property (@(posedge clk)
    (strobe.wr0 && strobe.wr1) |-> (strobe.wr0Idx != strobe.wr1Idx));
endmodule

// File: rtl/smt_uop_queue.sv
module smt_uop_queue
  import uopq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = QDEPTH,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        mode,
  input  logic              enqValid0,
  input  logic [DATA_W-1:0] enqData0,
  output logic              enqReady0,
  input  logic              enqValid1,
  input  logic [DATA_W-1:0] enqData1,
  output logic              enqReady1,
  input  logic              deqReq,
  input  logic              deqSel,
  output logic              deqValid,
  output logic [DATA_W-1:0] deqData,
  output logic [CW-1:0]     occ0,
  output logic [CW-1:0]     occ1
);
  uopq_strobe_t strobe;

  uopq_ctrl #(.DEPTH(DEPTH)) ctrl (
    .clk(clk), .rstN(rstN), .mode(mode),
    .enqValid0(enqValid0), .enqValid1(enqValid1),
    .enqReady0(enqReady0), .enqReady1(enqReady1),
    .deqReq(deqReq), .deqSel(deqSel), .deqValid(deqValid),
    .occ0(occ0), .occ1(occ1), .strobe(strobe));

  uopq_data #(.DEPTH(DEPTH), .DATA_W(DATA_W)) data (
    .clk(clk), .strobe(strobe), .wrData0(enqData0), .wrData1(enqData1),
    .rdData(deqData));
endmodule

// File: tb/smt_uop_queue_test.sv
module smt_uop_queue_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  mode = 2'b11;
  logic        enqValid0 = 1'b0, enqValid1 = 1'b0;
  logic [31:0] enqData0 = '0, enqData1 = '0;
  logic        enqReady0, enqReady1;
  logic        deqReq = 1'b0, deqSel = 1'b0;
  logic        deqValid;
  logic [31:0] deqData;
  logic [4:0]  occ0, occ1;

  int checks = 0;
  int failures = 0;
  int seqNo = 1;
  logic [31:0] q0[$];
  logic [31:0] q1[$];

  smt_uop_queue uut (
    .clk(clk), .rstN(rstN), .mode(mode),
    .enqValid0(enqValid0), .enqData0(enqData0), .enqReady0(enqReady0),
    .enqValid1(enqValid1), .enqData1(enqData1), .enqReady1(enqReady1),
    .deqReq(deqReq), .deqSel(deqSel), .deqValid(deqValid), .deqData(deqData),
    .occ0(occ0), .occ1(occ1));

  always #4 clk = ~clk;

  function automatic int qsize(input int t);
    return (t == 0) ? q0.size() : q1.size();
  endfunction

  function automatic logic expRdy(input int t);
    int lim = (mode == 2'b11) ? 8 : 16;
    return mode[t] && (qsize(t) < lim) && (q0.size() + q1.size() < 16);
  endfunction

  function automatic string rdyTag(input int t);
    if (!mode[t]) return "R5";
    if (q0.size() + q1.size() >= 16) return "R9";
    return (mode == 2'b11) ? "R3" : "R4";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive at the falling edge, compare, then update the model at the rising edge
  task automatic step(input logic v0, input logic v1, input logic rq, input logic sel,
                      input string deqTag);
    logic e0, e1, ev;
    logic [31:0] ed;
    enqValid0 = v0; enqData0 = 32'h1000_0000 | seqNo;
    enqValid1 = v1; enqData1 = 32'h2000_0000 | (seqNo + 1);
    deqReq = rq; deqSel = sel;
    seqNo += 2;
    #1;
    e0 = expRdy(0); e1 = expRdy(1);
    check(rdyTag(0), enqReady0, e0);
    check(rdyTag(1), enqReady1, e1);
    check("R9", occ0, q0.size());
    check("R9", occ1, q1.size());
    ev = rq && (qsize(sel) != 0);
    check((qsize(sel) == 0) ? "R7" : deqTag, deqValid, ev);
    if (ev) begin
      ed = sel ? q1[0] : q0[0];
      check(deqTag, deqData, ed);
    end
    @(posedge clk);
    if (ev) begin
      if (sel) void'(q1.pop_front()); else void'(q0.pop_front());
    end
    if (v0 && e0) q0.push_back(enqData0);
    if (v1 && e1) q1.push_back(enqData1);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state with both threads active
    #1;
    check("R1", occ0, 0);
    check("R1", occ1, 0);
    check("R1", enqReady0, 1);
    check("R1", enqReady1, 1);
    check("R1", deqValid, 0);
    @(negedge clk);

    // R7: empty dequeue does nothing
    step(0, 0, 1, 0, "R7");
    step(0, 0, 1, 1, "R7");
    check("R7", occ0, 0);

    // R4: thread 0 alone fills all 16
    mode = 2'b01;
    for (int i = 0; i < 17; i++) step(1, 1, 0, 0, "R4");
    check("R4", occ0, 16);
    check("R5", occ1, 0);

    // R6: switch to both threads with 16 held; thread 0 blocked until below 8
    mode = 2'b11;
    #1;
    check("R6", enqReady0, 0);
    check("R9", enqReady1, 0);
    for (int i = 0; i < 8; i++) step(1, 0, 1, 0, "R6");
    check("R6", occ0, 8);
    check("R6", enqReady0, 0);
    step(1, 0, 1, 0, "R6");
    check("R6", occ0, 7);
    check("R6", enqReady0, 1);

    // R8: two enqueues and one dequeue in the same cycle
    step(1, 1, 1, 0, "R8");
    check("R8", occ0, 7);
    check("R8", occ1, 1);
    step(1, 1, 1, 1, "R8");
    check("R8", occ0, 8);
    check("R8", occ1, 1);

    // R9: full pool blocks a thread below its own limit
    mode = 2'b10;
    for (int i = 0; i < 10; i++) step(0, 1, 0, 0, "R9");
    check("R9", occ1, 8);
    check("R9", enqReady1, 0);

    // R5: no thread active
    mode = 2'b00;
    step(1, 1, 0, 0, "R5");
    check("R5", enqReady0, 0);

    // R2: random mixed traffic with occasional mode changes
    for (int i = 0; i < 4000; i++) begin
      if ((i % 53) == 0) mode = 2'($urandom_range(0, 3));
      step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           ($urandom_range(0, 99) < 55), 1'($urandom_range(0, 1)), "R2");
    end
    mode = 2'b11;
    for (int i = 0; i < 40; i++) step(0, 0, 1, 1'(i % 2), "R2");
    check("R2", occ0, 0);
    check("R2", occ1, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule